// File: doc/BRIEF.md
# ADC Limit Watch

This block sits beside an analog-to-digital converter. It watches the stream of finished conversion results, each a 10-bit value tagged with a 4-bit channel number and marked by a one-cycle strobe. Three independent detectors each follow one chosen channel. A detector compares every result from its channel against a programmable limit and flags an event when the value is strictly above the limit or strictly below it, as the detector is configured.

A detector can also run with a second limit that releases it. In that mode it latches an "armed" state when the first limit is crossed. It flags only on entry into that state. It disarms only when the value moves back past the release limit, which gives hysteresis against a noisy input.

Events are kept in sticky status flags, which software clears by writing 1 to them. Per-detector interrupt enables gate the flags onto an interrupt line, and a single wake enable gates all of them onto a wake line. Software reaches everything through a small 16-bit register port with a 3-bit address:

- Addresses 0 to 2 hold the main control word of detectors 1 to 3.
- Addresses 3 to 5 hold their release-limit words.
- Address 6 holds the shared status/control word.

Top module: `adc_limit_watch`

## Requirements
- R1: After reset, every register reads 0, `det_status` is 0, and `irq` and `wake` are low.
- R2: Each control word reads back exactly as written. Each release word keeps bit 15 and bits 9:0, and its bits 14:10 read 0. The status word reads `{wake_en, 4'b0, ien[2:0], evt, 4'b0, status[2:0]}`. Address 7 reads 0 and ignores writes.
- R3: Control word fields are: bit 15 enable, bit 14 direction, bits 13:10 channel, bits 9:0 limit. Direction 1 means the event condition is sample > limit; direction 0 means sample < limit. A sample equal to the limit never triggers. With the release enable at 0, every triggering sample sets the status flag.
- R4: A sample is evaluated only by enabled detectors whose channel field equals the sample's channel. Any other sample leaves the status and the armed state unchanged.
- R5: Release word fields are: bit 15 release enable, bits 9:0 release limit. With the release enable at 1, a triggering sample sets the status only when the detector is not armed, and it arms the detector. Further triggering samples do not set the status again. The detector disarms on a sample strictly below the release limit (direction 1) or strictly above it (direction 0).
- R6: A detector whose enable bit is 0 never sets its status flag. Its armed state is cleared, so after re-enabling, the first triggering sample sets the status again.
- R7: Status flags are sticky. Writing 1 to status bit k (bits 2:0 of address 6) clears flag k, and writing 0 leaves it alone. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R8: `irq` is high exactly when some status flag and its interrupt enable (bit 8+k of the status word) are both 1.
- R9: `wake` is high exactly when the wake enable (bit 15 of the status word) is 1 and any status flag is 1.
- R10: Bit 7 of the status word reads 1 exactly when any status flag is 1; writes to it are ignored.
- R11: A sample presented with `smp_valid` at a clock edge shows in `det_status`, `irq` and `wake` right after that edge. No other change sets a flag.
- R12: Several detectors mapped to the same channel all evaluate the same sample in the same cycle, each under its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Conversion result strobe |
| smp_chan | input | 4 | Channel of the result |
| smp_data | input | 10 | Converted value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| det_status | output | 3 | Sticky per-detector status flags |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The assertions assume at most one result per clock, and inputs that are steady across each rising edge. They also assume a register write and a sample may land in the same cycle, with the write taking effect only for later samples. The stimulus drives every input one nanosecond after the edge and holds it for the full cycle. The random mix sends samples and writes together on purpose. Channel fields and sample channels are drawn from a small set so that detectors see matching results often, while mismatching channels still occur.

// File: rtl/alw_pkg.sv
package alw_pkg;
    localparam int NDET    = 3;
    localparam int CHW     = 4;
    localparam int DW      = 10;
    localparam int RW      = 16;
    localparam int AW      = 3;
    localparam int A_CTL0  = 0;
    localparam int A_DUAL0 = NDET;
    localparam int A_STS   = 2 * NDET;
    localparam int B_WEN   = RW - 1;
    localparam int B_IEN   = 8;
    localparam int B_EVT   = 7;

    typedef struct packed {
        logic           en;
        logic           above;
        logic [CHW-1:0] chan;
        logic [DW-1:0]  lim;
    } det_ctl_t;

    typedef struct packed {
        logic          en;
        logic [DW-1:0] rel;
    } det_dual_t;

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] chan;
        logic [DW-1:0]  data;
    } sample_t;

    function automatic logic [RW-1:0] dual_word(det_dual_t d);
        logic [RW-1:0] w;
        w = '0;
        w[RW-1] = d.en;
        w[DW-1:0] = d.rel;
        return w;
    endfunction

    function automatic logic [RW-1:0] sts_word(logic wen, logic [NDET-1:0] ien,
                                               logic [NDET-1:0] st);
        logic [RW-1:0] w;
        w = '0;
        w[B_WEN] = wen;
        w[B_IEN +: NDET] = ien;
        w[B_EVT] = |st;
        w[NDET-1:0] = st;
        return w;
    endfunction
endpackage

// File: rtl/alw_detector.sv
module alw_detector
    import alw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  det_ctl_t  ctl,
    input  det_dual_t dual,
    input  sample_t   smp,
    output logic      set_o
);
    logic match, hit, release_c, armed_q;

    always_comb begin
        match     = ctl.en & smp.valid & (smp.chan == ctl.chan);
        hit       = ctl.above ? (smp.data > ctl.lim) : (smp.data < ctl.lim);
        release_c = ctl.above ? (smp.data < dual.rel) : (smp.data > dual.rel);
        set_o     = match & hit & ~(dual.en & armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.en || !dual.en) begin
            armed_q <= 1'b0;
        end else if (match) begin
            if (!armed_q && hit)
                armed_q <= 1'b1;
            else if (armed_q && release_c)
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/alw_regbank.sv
module alw_regbank
    import alw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [RW-1:0]         wdata,
    input  logic [NDET-1:0]       set_i,
    output det_ctl_t  [NDET-1:0]  ctl_o,
    output det_dual_t [NDET-1:0]  dual_o,
    output logic [NDET-1:0]       stat_o,
    output logic [NDET-1:0]       ien_o,
    output logic                  wen_o,
    output logic [RW-1:0]         rdata
);
    logic sts_hit;
    logic [NDET-1:0] clr;

    assign sts_hit = we && (addr == AW'(A_STS));
    assign clr     = sts_hit ? wdata[NDET-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o  <= '0;
            dual_o <= '0;
            stat_o <= '0;
            ien_o  <= '0;
            wen_o  <= 1'b0;
        end else begin
            for (int i = 0; i < NDET; i++) begin
                if (we && addr == AW'(A_CTL0 + i))
                    ctl_o[i] <= det_ctl_t'(wdata);
                if (we && addr == AW'(A_DUAL0 + i))
                    dual_o[i] <= '{en: wdata[RW-1], rel: wdata[DW-1:0]};
            end
            if (sts_hit) begin
                wen_o <= wdata[B_WEN];
                ien_o <= wdata[B_IEN +: NDET];
            end
            stat_o <= (stat_o & ~clr) | set_i;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_STS))
            rdata = sts_word(wen_o, ien_o, stat_o);
        for (int i = 0; i < NDET; i++) begin
            if (addr == AW'(A_CTL0 + i))
                rdata = ctl_o[i];
            if (addr == AW'(A_DUAL0 + i))
                rdata = dual_word(dual_o[i]);
        end
    end
endmodule

// File: rtl/adc_limit_watch.sv
module adc_limit_watch
    import alw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_valid,
    input  logic [CHW-1:0]  smp_chan,
    input  logic [DW-1:0]   smp_data,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    output logic [NDET-1:0] det_status,
    output logic            irq,
    output logic            wake
);
    sample_t              smp;
    det_ctl_t  [NDET-1:0] ctl;
    det_dual_t [NDET-1:0] dual;
    logic [NDET-1:0]      set_v;
    logic [NDET-1:0]      ien;
    logic [NDET-1:0]      det_en;
    logic                 wen;

    assign smp = '{valid: smp_valid, chan: smp_chan, data: smp_data};

    alw_regbank u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .set_i  (set_v),
        .ctl_o  (ctl),
        .dual_o (dual),
        .stat_o (det_status),
        .ien_o  (ien),
        .wen_o  (wen),
        .rdata  (reg_rdata)
    );

    for (genvar g = 0; g < NDET; g++) begin : g_det
        alw_detector u_det (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl[g]),
            .dual  (dual[g]),
            .smp   (smp),
            .set_o (set_v[g])
        );
        assign det_en[g] = ctl[g].en;
    end

    assign irq  = |(det_status & ien);
    assign wake = wen & (|det_status);
endmodule

// File: rtl/alw_checker.sv
module alw_checker
    import alw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            smp_valid,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [NDET-1:0] wclr,
    input logic            evt_bit,
    input logic [NDET-1:0] det_status,
    input logic [NDET-1:0] det_en,
    input logic            irq,
    input logic            wake
);
    AST_SET_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) (|(det_status & ~$past(det_status))) |-> $past(smp_valid)); // R11
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst) $past(smp_valid) |-> ((det_status & ~$past(det_status) & ~$past(det_en)) == '0)); // R6
    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst) !($past(reg_we) && $past(reg_addr) == AW'(A_STS)) |-> ((det_status & $past(det_status)) == $past(det_status))); // R7
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst) ($past(reg_we) && $past(reg_addr) == AW'(A_STS)) |-> ((det_status & $past(det_status) & ~$past(wclr)) == ($past(det_status) & ~$past(wclr)))); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> (|det_status)); // R8
    AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) wake |-> (|det_status)); // R9
    AST_EVT_MIRRORS: assert property (@(posedge clk) disable iff (rst) (reg_addr == AW'(A_STS)) |-> (evt_bit == (|det_status))); // R10
endmodule

bind adc_limit_watch alw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wclr       (reg_wdata[alw_pkg::NDET-1:0]),
    .evt_bit    (reg_rdata[alw_pkg::B_EVT]),
    .det_status (det_status),
    .det_en     (det_en),
    .irq        (irq),
    .wake       (wake)
);

// File: tb/sim_adc_limit_watch.sv
`timescale 1ns/1ps
module sim_adc_limit_watch;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sv = 1'b0;
    logic [3:0] ch = '0;
    logic [9:0] dat = '0;
    logic we = 1'b0;
    logic [2:0] addr = '0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic [2:0] stat;
    logic irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_ctl [3];
    logic [15:0] m_dual [3];
    logic [2:0]  m_arm, m_stat, m_ien;
    logic        m_wen;

    always #2 clk = ~clk;

    adc_limit_watch u0 (
        .clk(clk), .rst(rst), .smp_valid(sv), .smp_chan(ch), .smp_data(dat),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rdata),
        .det_status(stat), .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        if (a < 3) return m_ctl[a];
        if (a < 6) return {m_dual[a-3][15], 5'b0, m_dual[a-3][9:0]};
        if (a == 6) return {m_wen, 4'b0, m_ien, |m_stat, 4'b0, m_stat};
        return 16'h0000;
    endfunction

    task automatic model_step(input logic w, input logic [2:0] a, input logic [15:0] d,
                              input logic v, input logic [3:0] c, input logic [9:0] x);
        logic [2:0] setv;
        setv = '0;
        for (int i = 0; i < 3; i++) begin
            logic en, ab, de, m, hit, rel;
            en  = m_ctl[i][15];
            ab  = m_ctl[i][14];
            de  = m_dual[i][15];
            m   = en && v && (c == m_ctl[i][13:10]);
            hit = ab ? (x > m_ctl[i][9:0]) : (x < m_ctl[i][9:0]);
            rel = ab ? (x < m_dual[i][9:0]) : (x > m_dual[i][9:0]);
            setv[i] = m && hit && !(de && m_arm[i]);
            if (!en || !de) m_arm[i] = 1'b0;
            else if (m) begin
                if (!m_arm[i] && hit) m_arm[i] = 1'b1;
                else if (m_arm[i] && rel) m_arm[i] = 1'b0;
            end
        end
        if (w && a < 3) m_ctl[a] = d;
        if (w && a >= 3 && a < 6) m_dual[a-3] = {d[15], 5'b0, d[9:0]};
        if (w && a == 6) begin
            m_wen  = d[15];
            m_ien  = d[10:8];
            m_stat = m_stat & ~d[2:0];
        end
        m_stat = m_stat | setv;
    endtask

    task automatic compare_out();
        chk("R3 R5 R12 status", {13'b0, stat}, {13'b0, m_stat});
        chk("R8 irq", {15'b0, irq}, {15'b0, |(m_stat & m_ien)});
        chk("R9 wake", {15'b0, wake}, {15'b0, m_wen & (|m_stat)});
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                       input logic v, input logic [3:0] c, input logic [9:0] x);
        we = w; addr = a; wd = d; sv = v; ch = c; dat = x;
        @(posedge clk);
        model_step(w, a, d, v, c, x);
        #1;
        we = 1'b0; sv = 1'b0;
        compare_out();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0, 4'd0, 10'd0);
    endtask

    task automatic smp(input logic [3:0] c, input logic [9:0] x);
        cyc(1'b0, 3'd0, 16'h0, 1'b1, c, x);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp_read(a));
    endtask

    function automatic logic [15:0] ctlw(input logic en, input logic ab,
                                         input logic [3:0] c, input logic [9:0] l);
        return {en, ab, c, l};
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < 3; i++) begin m_ctl[i] = '0; m_dual[i] = '0; end
        m_arm = '0; m_stat = '0; m_ien = '0; m_wen = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        compare_out();
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset readback");

        // R2: register map
        wr(3'd0, 16'hFFFF); rd(3'd0, "R2 ctl readback");
        wr(3'd3, 16'hFFFF); rd(3'd3, "R2 dual readback");
        chk("R2 dual reserved bits", rdata, 16'h83FF);
        wr(3'd6, 16'hFFF8); rd(3'd6, "R2 status word");
        chk("R2 status layout", rdata, 16'h8700);
        wr(3'd7, 16'hFFFF); rd(3'd7, "R2 unmapped addr");
        wr(3'd0, 16'h0); wr(3'd3, 16'h0); wr(3'd6, 16'h0);

        // R3: single limit, above and below, equality
        wr(3'd0, ctlw(1, 1, 4'd2, 10'd500));
        smp(4'd2, 10'd500); chk("R3 equal above no set", {13'b0, stat}, 16'h0);
        smp(4'd2, 10'd501); chk("R3 above sets", {13'b0, stat}, 16'h1);
        wr(3'd6, 16'h0001);
        smp(4'd2, 10'd900); chk("R3 single re-sets every hit", {13'b0, stat}, 16'h1);
        wr(3'd6, 16'h0001);
        wr(3'd0, ctlw(1, 0, 4'd2, 10'd100));
        smp(4'd2, 10'd100); chk("R3 equal below no set", {13'b0, stat}, 16'h0);
        smp(4'd2, 10'd99);  chk("R3 below sets", {13'b0, stat}, 16'h1);
        wr(3'd6, 16'h0001);

        // R4: other channel ignored
        smp(4'd3, 10'd0); chk("R4 other channel no effect", {13'b0, stat}, 16'h0);

        // R7: sticky, write 0 keeps, set beats clear
        smp(4'd2, 10'd5);
        wr(3'd6, 16'h0000); chk("R7 write 0 keeps flag", {13'b0, stat}, 16'h1);
        wr(3'd6, 16'h0001); chk("R7 write 1 clears", {13'b0, stat}, 16'h0);
        smp(4'd2, 10'd5);
        cyc(1'b1, 3'd6, 16'h0001, 1'b1, 4'd2, 10'd5);
        chk("R7 set wins over clear", {13'b0, stat}, 16'h1);
        wr(3'd6, 16'h0007);
        wr(3'd0, 16'h0);

        // R5: hysteresis pair on detector 2
        wr(3'd4, {1'b1, 5'b0, 10'd400});
        wr(3'd1, ctlw(1, 1, 4'd1, 10'd600));
        smp(4'd1, 10'd700); chk("R5 entry sets", {13'b0, stat}, 16'h2);
        wr(3'd6, 16'h0002);
        smp(4'd1, 10'd650); chk("R5 armed no re-set", {13'b0, stat}, 16'h0);
        smp(4'd1, 10'd400); chk("R5 at release no disarm", {13'b0, stat}, 16'h0);
        smp(4'd1, 10'd700); chk("R5 still armed", {13'b0, stat}, 16'h0);
        smp(4'd1, 10'd399);
        smp(4'd1, 10'd601); chk("R5 re-entry sets", {13'b0, stat}, 16'h2);
        wr(3'd6, 16'h0002);

        // R6: disable clears armed state
        wr(3'd1, ctlw(0, 1, 4'd1, 10'd600));
        smp(4'd1, 10'd800); chk("R6 disabled no set", {13'b0, stat}, 16'h0);
        wr(3'd1, ctlw(1, 1, 4'd1, 10'd600));
        smp(4'd1, 10'd800); chk("R6 re-enable sets again", {13'b0, stat}, 16'h2);

        // R8 R9 R10: gating and event flag
        wr(3'd6, 16'h0100); chk("R8 irq masked", {15'b0, irq}, 16'h0);
        wr(3'd6, 16'h0200); chk("R8 irq enabled", {15'b0, irq}, 16'h1);
        chk("R9 wake off", {15'b0, wake}, 16'h0);
        wr(3'd6, 16'h8000); chk("R9 wake on", {15'b0, wake}, 16'h1);
        rd(3'd6, "R10 event flag set");
        wr(3'd6, 16'h8002); rd(3'd6, "R10 event flag clear");
        chk("R9 wake drops", {15'b0, wake}, 16'h0);

        // R12: two detectors on one channel
        wr(3'd0, ctlw(1, 1, 4'd5, 10'd10));
        wr(3'd2, ctlw(1, 0, 4'd5, 10'd900));
        smp(4'd5, 10'd50); chk("R12 shared channel", {13'b0, stat}, 16'h5);
        wr(3'd6, 16'h0007);

        // random mix, R11 timing checked every cycle
        for (int n = 0; n < 4000; n++) begin
            logic w, v;
            logic [2:0] a;
            logic [15:0] d;
            w = ($urandom % 4) == 0;
            v = ($urandom % 10) < 6;
            a = 3'($urandom % 8);
            d = 16'($urandom);
            if (a < 3) d[13:10] = 4'($urandom % 4);
            cyc(w, a, d, v, 4'($urandom % 5), 10'($urandom));
            if ((n % 16) == 0) rd(3'($urandom % 8), "R2 R10 random readback");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule